// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the accumulator datapath of a small 8-bit controller core. Each cycle in which `op_en` is high, it takes a 5-bit operation code and an 8-bit operand supplied by the surrounding core. It then updates the internal accumulator and the upper four bits of the status word: carry, auxiliary carry and two user flags. The operations cover binary addition with and without carry-in, bitwise logic, increment and decrement, complement and clear, BCD decimal adjust, four rotates, nibble swap and a low-nibble exchange with a memory byte. There are also flag set, clear and complement operations and direct loads of the accumulator and of the flags.

The block drives two write-enables, `acc_we` and `flag_we`. They tell the core which state the present operation commits. For the low-nibble exchange it also returns the byte to be written back to memory on `mem_wdata`, qualified by `mem_we`. Operand fetch, decoding and memory access belong to the rest of the core.

Top module: `acc_alu`

## Requirements
- R1: After an active-low reset, `acc_q` is 00h and `flags_q` is 0000b. The flag bits map to status-word bits 7..4: `flags_q[3]` is carry (C), `flags_q[2]` is auxiliary carry (AC), `flags_q[1]` is F0 and `flags_q[0]` is F1.
- R2: ADD (op 2) sets A to A+operand. ADDC (op 3) sets A to A+operand+C. Both set C to the carry out of bit 7 and AC to the carry out of bit 3. Both leave F0 and F1 unchanged. ADD ignores the incoming C.
- R3: AND (4), OR (5), XOR (6), CPL (7, A=~A), CLR (8, A=0), INC (9) and DEC (10, both modulo 256) write A and leave all four flags unchanged, with `flag_we` low.
- R4: RLC (13) sets A to {A[6:0],C} and C to the old A[7]. RRC (14) sets A to {C,A[7:1]} and C to the old A[0]. Both leave AC, F0 and F1 unchanged.
- R5: RL (12) and RR (15) rotate the 8 accumulator bits without carry and leave all flags unchanged.
- R6: SWAP (16) exchanges A[7:4] and A[3:0]. XCHD (17) sets A to {A[7:4],operand[3:0]}. In the same cycle it drives `mem_wdata`={operand[7:4],A[3:0]} with `mem_we` high. `mem_we` is low for every other operation.
- R7: CLRC (18) clears C. CPLC (19) inverts C. CLRF0 (20) and CPLF0 (21) act only on F0, and CLRF1 (22) and CPLF1 (23) act only on F1. None of them changes A or any other flag.
- R8: DA (11) first adds 06h to A (modulo 256) when A[3:0]>9 or AC=1. It then adds 60h when the upper nibble of that result is >9 or C=1, and sets C in that case. DA never clears C and leaves AC, F0 and F1 unchanged.
- R9: When `op_en` is low, or the code is NOP (0) or unused (25..31), neither A nor the flags change. In that case `acc_we`, `flag_we` and `mem_we` are low.
- R10: LDA (1) loads A from the operand. LDF (24) loads the four flags from operand[7:4] in the R1 bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Execute the operation this cycle |
| op | input | 5 | Operation code |
| operand | input | 8 | Register, immediate or memory operand |
| acc_q | output | 8 | Accumulator |
| flags_q | output | 4 | Status-word bits 7..4 (C, AC, F0, F1) |
| acc_we | output | 1 | Operation writes the accumulator |
| flag_we | output | 1 | Operation writes the flags |
| mem_we | output | 1 | Operation writes a memory byte back |
| mem_wdata | output | 8 | Memory byte to write back |

## Verification
Two updates can fall in one cycle. The carry-rotates and decimal adjust write the accumulator and the carry together, and both are computed from the old values. XCHD changes the accumulator and produces the memory byte in the same cycle. The bench sweeps every accumulator value under all four C/AC combinations and every code. Before each operation it loads state, then checks the comparison-cycle enables and `mem_wdata`, and checks the registered results one cycle later against an arithmetic model.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_en,
  input  logic [4:0] op,
  input  logic [7:0] operand,
  output logic [7:0] acc_q,
  output logic [3:0] flags_q,
  output logic       acc_we,
  output logic       flag_we,
  output logic       mem_we,
  output logic [7:0] mem_wdata
);

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,  OP_LDA  = 5'd1,  OP_ADD  = 5'd2,  OP_ADDC = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_CPL  = 5'd7,
    OP_CLR  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_DA   = 5'd11,
    OP_RL   = 5'd12, OP_RLC  = 5'd13, OP_RRC  = 5'd14, OP_RR   = 5'd15,
    OP_SWAP = 5'd16, OP_XCHD = 5'd17, OP_CLRC = 5'd18, OP_CPLC = 5'd19,
    OP_CLF0 = 5'd20, OP_CPF0 = 5'd21, OP_CLF1 = 5'd22, OP_CPF1 = 5'd23,
    OP_LDF  = 5'd24
  } op_e;

  localparam int C_B  = 3;
  localparam int AC_B = 2;
  localparam int F0_B = 1;
  localparam int F1_B = 0;

  op_e        opc;
  logic       cy, acy;
  logic       cin;
  logic [8:0] sum;
  logic [4:0] nib;
  logic       lo_adj, hi_adj;
  logic [7:0] da1, da2;
  logic [7:0] acc_d;
  logic [3:0] flags_d;

  assign opc = op_e'(op);
  assign cy  = flags_q[C_B];
  assign acy = flags_q[AC_B];

  assign cin = (opc == OP_ADDC) & cy;
  assign sum = {1'b0, acc_q} + {1'b0, operand} + {8'd0, cin};
  assign nib = {1'b0, acc_q[3:0]} + {1'b0, operand[3:0]} + {4'd0, cin};

  assign lo_adj = (acc_q[3:0] > 4'd9) | acy;
  assign da1    = acc_q + (lo_adj ? 8'h06 : 8'h00);
  assign hi_adj = (da1[7:4] > 4'd9) | cy;
  assign da2    = da1 + (hi_adj ? 8'h60 : 8'h00);

  assign mem_we    = op_en & (opc == OP_XCHD);
  assign mem_wdata = {operand[7:4], acc_q[3:0]};

  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    acc_we  = 1'b0;
    flag_we = 1'b0;
    unique case (opc)
      OP_LDA:  begin acc_d = operand;           acc_we = 1'b1; end
      OP_ADD, OP_ADDC: begin
        acc_d = sum[7:0];
        flags_d[C_B]  = sum[8];
        flags_d[AC_B] = nib[4];
        acc_we = 1'b1; flag_we = 1'b1;
      end
      OP_AND:  begin acc_d = acc_q & operand;   acc_we = 1'b1; end
      OP_OR:   begin acc_d = acc_q | operand;   acc_we = 1'b1; end
      OP_XOR:  begin acc_d = acc_q ^ operand;   acc_we = 1'b1; end
      OP_CPL:  begin acc_d = ~acc_q;            acc_we = 1'b1; end
      OP_CLR:  begin acc_d = 8'h00;             acc_we = 1'b1; end
      OP_INC:  begin acc_d = acc_q + 8'd1;      acc_we = 1'b1; end
      OP_DEC:  begin acc_d = acc_q - 8'd1;      acc_we = 1'b1; end
      OP_DA: begin
        acc_d = da2;
        flags_d[C_B] = cy | hi_adj;
        acc_we = 1'b1; flag_we = 1'b1;
      end
      OP_RL:   begin acc_d = {acc_q[6:0], acc_q[7]}; acc_we = 1'b1; end
      OP_RR:   begin acc_d = {acc_q[0], acc_q[7:1]}; acc_we = 1'b1; end
      OP_RLC: begin
        acc_d = {acc_q[6:0], cy};
        flags_d[C_B] = acc_q[7];
        acc_we = 1'b1; flag_we = 1'b1;
      end
      OP_RRC: begin
        acc_d = {cy, acc_q[7:1]};
        flags_d[C_B] = acc_q[0];
        acc_we = 1'b1; flag_we = 1'b1;
      end
      OP_SWAP: begin acc_d = {acc_q[3:0], acc_q[7:4]};   acc_we = 1'b1; end
      OP_XCHD: begin acc_d = {acc_q[7:4], operand[3:0]}; acc_we = 1'b1; end
      OP_CLRC: begin flags_d[C_B]  = 1'b0;           flag_we = 1'b1; end
      OP_CPLC: begin flags_d[C_B]  = ~cy;            flag_we = 1'b1; end
      OP_CLF0: begin flags_d[F0_B] = 1'b0;           flag_we = 1'b1; end
      OP_CPF0: begin flags_d[F0_B] = ~flags_q[F0_B]; flag_we = 1'b1; end
      OP_CLF1: begin flags_d[F1_B] = 1'b0;           flag_we = 1'b1; end
      OP_CPF1: begin flags_d[F1_B] = ~flags_q[F1_B]; flag_we = 1'b1; end
      OP_LDF:  begin flags_d = operand[7:4];         flag_we = 1'b1; end
      default: ;
    endcase
    if (!op_en) begin
      acc_we  = 1'b0;
      flag_we = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 8'h00;
      flags_q <= 4'h0;
    end else begin
      if (acc_we)  acc_q   <= acc_d;
      if (flag_we) flags_q <= flags_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(acc_q) && $stable(flags_q)); // R9
  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op >= 5'd4 && op <= 5'd10 |=> $stable(flags_q)); // R3
  AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == 5'd13 |=> flags_q[3] == $past(acc_q[7]) && acc_q[0] == $past(flags_q[3])); // R4
  AST_RR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == 5'd15 |=> $stable(flags_q) && acc_q == {$past(acc_q[0]), $past(acc_q[7:1])}); // R5
  AST_DA_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == 5'd11 && flags_q[3] |=> flags_q[3]); // R8
  AST_CLRC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == 5'd18 |=> !flags_q[3] && $stable(acc_q) && $stable(flags_q[2:0])); // R7
  AST_MEM_WE_XCHD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> op_en && op == 5'd17); // R6

endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/100ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc_q;
  logic [3:0] flags_q;
  logic       acc_we, flag_we, mem_we;
  logic [7:0] mem_wdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .operand(operand),
    .acc_q(acc_q), .flags_q(flags_q), .acc_we(acc_we), .flag_we(flag_we),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic string req_of(input int c);
    if (c == 1 || c == 24) return "R10";
    if (c == 2 || c == 3) return "R2";
    if (c >= 4 && c <= 10) return "R3";
    if (c == 11) return "R8";
    if (c == 13 || c == 14) return "R4";
    if (c == 12 || c == 15) return "R5";
    if (c == 16 || c == 17) return "R6";
    if (c >= 18 && c <= 23) return "R7";
    return "R9";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int c, input int v);
    @(negedge clk);
    op = 5'(c); operand = 8'(v); op_en = 1'b1;
    @(negedge clk);
    op_en = 1'b0;
  endtask

  task automatic exec_check(input int c, input int a, input int v, input int fl);
    int ea, ef, c_in, s, n, t, ewa, ewf, ewm, lo, hi;
    ea = a; ef = fl; ewa = 1; ewf = 0; ewm = 0;
    case (c)
      1:  ea = v;
      2, 3: begin
        c_in = (c == 3) ? (fl >> 3) & 1 : 0;
        s = a + v + c_in;
        n = (a % 16) + (v % 16) + c_in;
        ea = s % 256;
        ef = (fl % 4) + ((s >= 256) ? 8 : 0) + ((n >= 16) ? 4 : 0);
        ewf = 1;
      end
      4:  ea = a & v;
      5:  ea = a | v;
      6:  ea = a ^ v;
      7:  ea = 255 - a;
      8:  ea = 0;
      9:  ea = (a + 1) % 256;
      10: ea = (a + 255) % 256;
      11: begin
        t = a;
        lo = ((a % 16) > 9) || ((fl >> 2) & 1);
        if (lo) t = (t + 6) % 256;
        hi = ((t / 16) > 9) || ((fl >> 3) & 1);
        if (hi) begin t = (t + 96) % 256; ef = fl | 8; end
        ea = t; ewf = 1;
      end
      12: ea = ((a * 2) % 256) + (a / 128);
      15: ea = (a / 2) + ((a % 2) * 128);
      13: begin ea = ((a * 2) % 256) + ((fl >> 3) & 1); ef = (fl & 7) | ((a / 128) * 8); ewf = 1; end
      14: begin ea = (a / 2) + (((fl >> 3) & 1) * 128); ef = (fl & 7) | ((a % 2) * 8); ewf = 1; end
      16: ea = ((a % 16) * 16) + (a / 16);
      17: begin ea = (a / 16) * 16 + (v % 16); ewm = 1; end
      18: begin ewa = 0; ewf = 1; ef = fl & 7; end
      19: begin ewa = 0; ewf = 1; ef = fl ^ 8; end
      20: begin ewa = 0; ewf = 1; ef = fl & 13; end
      21: begin ewa = 0; ewf = 1; ef = fl ^ 2; end
      22: begin ewa = 0; ewf = 1; ef = fl & 14; end
      23: begin ewa = 0; ewf = 1; ef = fl ^ 1; end
      24: begin ewa = 0; ewf = 1; ef = v / 16; end
      default: begin ewa = 0; end
    endcase
    @(negedge clk);
    op = 5'(c); operand = 8'(v); op_en = 1'b1;
    #1;
    check(req_of(c), "acc_we", int'(acc_we), ewa);
    check(req_of(c), "flag_we", int'(flag_we), ewf);
    check(ewm ? "R6" : req_of(c), "mem_we", int'(mem_we), ewm);
    if (ewm) check("R6", "mem_wdata", int'(mem_wdata), (v / 16) * 16 + (a % 16));
    @(negedge clk);
    op_en = 1'b0;
    check(req_of(c), $sformatf("acc op%0d a=%0h v=%0h f=%0h", c, a, v, fl), int'(acc_q), ea);
    check(req_of(c), $sformatf("flags op%0d a=%0h v=%0h f=%0h", c, a, v, fl), int'(flags_q), ef);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset acc", int'(acc_q), 0);
    check("R1", "reset flags", int'(flags_q), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 32; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int ca = 0; ca < 4; ca++) begin
          int fl, v;
          fl = ca * 4 + (a % 4);
          v  = (a * 37 + c * 11 + ca * 91 + 13) % 256;
          run_op(24, fl * 16);
          run_op(1, a);
          exec_check(c, a, v, fl);
        end
      end
    end

    // R9: idle cycles with an active code leave state untouched
    run_op(24, 8'hA0);
    run_op(1, 8'hFF);
    @(negedge clk);
    op = 5'd2; operand = 8'h01; op_en = 1'b0;
    #1;
    check("R9", "idle acc_we", int'(acc_we), 0);
    check("R9", "idle flag_we", int'(flag_we), 0);
    @(negedge clk);
    check("R9", "idle acc", int'(acc_q), 8'hFF);
    check("R9", "idle flags", int'(flags_q), 4'hA);

    // R2: ADD ignores carry-in, ADDC uses it
    run_op(24, 8'h80);
    run_op(1, 8'h0F);
    exec_check(2, 8'h0F, 8'h01, 8);
    run_op(24, 8'h80);
    run_op(1, 8'hFF);
    exec_check(3, 8'hFF, 8'h00, 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule